// File: doc/BRIEF.md
# Next Fetch Address Sequencer

This block holds the program counter of a processor with fixed 32-bit instructions and picks the next fetch address on every clock. The decode stage supplies a control-flow kind, two operands for the equality test of a conditional branch, a 16-bit word offset, a 26-bit jump field and a register value for indirect jumps. The sequencer turns these into the next PC. Alongside the PC it presents the link value, PC+4, which the datapath writes back on a call.

A stall input freezes the PC. A synchronous reset returns it to zero. An indirect jump to an address that is not word aligned is still taken, and a flag reports it in the same cycle.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the next `pc` is 0x00000000. This holds even if `stall` is high.
- R2: The control-flow kind is 3 bits wide. Its codes are: 0 sequential, 1 branch-if-equal, 2 branch-if-different, 3 jump, 4 jump-and-link, 5 register jump. Codes 6 and 7 act as sequential. Sequential flow loads pc+4.
- R3: Branch-if-equal is taken when `opa == opb`. Branch-if-different is taken when the two differ.
- R4: A taken branch loads pc + 4 + (sign-extended `boff`) × 4. Negative offsets therefore move backward.
- R5: An untaken branch loads pc+4.
- R6: Jump and jump-and-link load {pc[31:28], `jfield`, 2'b00}. The top four bits of the PC are kept.
- R7: A register jump loads `rjump` exactly as given. `misalign` is high in that same cycle when `rjump[1:0]` is not zero. `misalign` is low for every other kind.
- R8: `link` always equals pc+4, with 32-bit wraparound. `link_we` is high only when the kind is jump-and-link.
- R9: When `stall` is high and `rst` is low, the PC keeps its value, whatever the kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Holds the PC |
| kind | input | 3 | Control-flow kind code |
| opa | input | 32 | First operand of the equality test |
| opb | input | 32 | Second operand of the equality test |
| boff | input | 16 | Branch offset, in instructions, two's complement |
| jfield | input | 26 | Pseudo-direct jump field |
| rjump | input | 32 | Target of a register jump |
| pc | output | 32 | Current fetch address |
| link | output | 32 | pc+4, the return address |
| link_we | output | 1 | The link should be written to the return-address register |
| misalign | output | 1 | A register jump target is not word aligned |

## Verification
The sequencer's only state is the PC. A wrong next-address choice therefore shows on `pc` one edge after the cycle that caused it, and `link` is off by the same amount at that moment. From then on every later address is offset by the error. So the reference model compares `pc` and `link` on every clock, and a fault is reported on the first cycle after it happens rather than being left to build up. Branches are driven with both equal and unequal operands, with positive and negative offsets, and with jumps near the top-bits boundary of the address, so each way of forming an address is exercised separately.

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int JW = 26
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic [2:0]    kind,
  input  logic [AW-1:0] opa,
  input  logic [AW-1:0] opb,
  input  logic [OW-1:0] boff,
  input  logic [JW-1:0] jfield,
  input  logic [AW-1:0] rjump,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] link,
  output logic          link_we,
  output logic          misalign
);
  localparam int HI = AW - JW - 2;
  localparam logic [2:0] K_BEQ = 3'd1, K_BNE = 3'd2, K_J = 3'd3, K_JAL = 3'd4, K_JR = 3'd5;

  logic [AW-1:0] seq, btgt, jtgt, nxt;
  logic          same, taken;

  assign seq  = pc + AW'(4);
  assign link = seq;
  assign same = (opa == opb);
  assign taken = (kind == K_BEQ && same) || (kind == K_BNE && !same);
  assign btgt = seq + {{(AW-OW-2){boff[OW-1]}}, boff, 2'b00};
  assign jtgt = {pc[AW-1 -: HI], jfield, 2'b00};
  assign link_we = (kind == K_JAL);
  assign misalign = (kind == K_JR) && (rjump[1:0] != 2'b00);

  always_comb begin
    case (kind)
      K_BEQ, K_BNE: nxt = taken ? btgt : seq;
      K_J, K_JAL:   nxt = jtgt;
      K_JR:         nxt = rjump;
      default:      nxt = seq;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         pc <= '0;
    else if (!stall) pc <= nxt;
  end

  logic seen;
  always_ff @(posedge clk) seen <= 1'b1;

  a_r1_reset_zero: assert property (@(posedge clk) seen && rst |=> pc == '0);
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst) seen && stall |=> $stable(pc));
  a_r6_region_kept: assert property (@(posedge clk) disable iff (rst)
    seen && !stall && (kind == K_J || kind == K_JAL) |=> pc[AW-1 -: HI] == $past(pc[AW-1 -: HI]));
  a_r7_jr_exact: assert property (@(posedge clk) disable iff (rst)
    seen && !stall && kind == K_JR |=> pc == $past(rjump));
  a_r8_link_step: assert property (@(posedge clk) link - pc == AW'(4));
  a_r5_untaken_seq: assert property (@(posedge clk) disable iff (rst)
    seen && !stall && kind == K_BEQ && opa != opb |=> pc == $past(pc) + AW'(4));
endmodule

// File: tb/sim_pc_sequencer.sv
module sim_pc_sequencer;
  logic clk = 0, rst = 1, stall = 0;
  logic [2:0] kind = 0;
  logic [31:0] opa = 0, opb = 0, rjump = 0;
  logic [15:0] boff = 0;
  logic [25:0] jfield = 0;
  logic [31:0] pc, link;
  logic link_we, misalign;
  int total = 0, bad = 0;
  int unsigned model = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pc_sequencer u0 (.clk, .rst, .stall, .kind, .opa, .opb, .boff, .jfield, .rjump,
                   .pc, .link, .link_we, .misalign);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int unsigned ref_next(int unsigned p);
    int signed off;
    if (rst) return 0;
    if (stall) return p;
    off = int'(signed'(boff));
    case (kind)
      3'd1: return (opa == opb) ? p + 4 + off * 4 : p + 4;
      3'd2: return (opa != opb) ? p + 4 + off * 4 : p + 4;
      3'd3, 3'd4: return {p[31:28], jfield, 2'b00};
      3'd5: return rjump;
      default: return p + 4;
    endcase
  endfunction

  task automatic step(string req, logic s, logic [2:0] k, logic [31:0] a, logic [31:0] b,
                      logic [15:0] o, logic [25:0] j, logic [31:0] r);
    stall = s; kind = k; opa = a; opb = b; boff = o; jfield = j; rjump = r;
    #1;
    chk({req, " link"}, link, model + 4);
    chk({req, " link_we"}, {31'd0, link_we}, {31'd0, k == 3'd4});
    chk({req, " misalign"}, {31'd0, misalign}, {31'd0, k == 3'd5 && r[1:0] != 0});
    model = ref_next(model);
    @(posedge clk); #2;
    chk({req, " pc"}, pc, model);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #2 chk("R1 reset", pc, 0);
    rst = 0;
    step("R2", 0, 0, 0, 0, 0, 0, 0);
    step("R2", 0, 7, 0, 0, 0, 0, 0);
    step("R3/R4 beq taken", 0, 1, 5, 5, 16'd10, 0, 0);
    step("R5 beq untaken", 0, 1, 5, 6, 16'd10, 0, 0);
    step("R4 bne back", 0, 2, 1, 2, 16'hFFFD, 0, 0);
    step("R5 bne untaken", 0, 2, 9, 9, 16'h0040, 0, 0);
    step("R7 jr", 0, 5, 0, 0, 0, 0, 32'hF000_0010);
    step("R6 j region", 0, 3, 0, 0, 0, 26'h3FF_FFFF, 0);
    step("R6 jal", 0, 4, 0, 0, 0, 26'h000_0123, 0);
    step("R9 stall", 1, 3, 0, 0, 0, 26'h1, 0);
    step("R9 stall jr", 1, 5, 0, 0, 0, 0, 32'h40);
    step("R7 misalign", 0, 5, 0, 0, 0, 0, 32'hFFFF_FFFE);
    step("R8 wrap", 0, 0, 0, 0, 0, 0, 0);
    step("R8 wrap2", 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++)
      step("R4 mix", i % 5 == 4, 3'(i % 6), 32'(i & 1), 0, 16'(i * 977), 26'(i * 40503), 32'(i * 4));
    rst = 1; stall = 1; model = 0;
    @(posedge clk); #2 chk("R1 reset over stall", pc, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule